// File: doc/BRIEF.md
# Seconds-Granular Watchdog with Locking Enable

This block is a watchdog timer that sits in a small register-mapped control block and counts whole seconds. A prescaler divides the system clock down to a one-second tick, and a four-bit seconds counter is compared against a programmable timeout. Software starts the watchdog by setting an enable bit in the control register. Once set, that bit stays set until the next system reset. Every write to the control register restarts the timeout, whatever value is written. If the timeout elapses without a write, the block drives a reset request for a fixed number of cycles.

The block also keeps a reset-cause flag. The flag lives in the power-on reset domain, so it survives the system reset that the watchdog itself triggers. After reboot, software reads the flag to learn whether the watchdog caused the last reset, and then clears it by writing a one to it. A read-only word reports a firmware version number.

Top module: `sec_watchdog`

## Requirements
- R1: After power-on reset, `wdt_rst_req` is low, the control register (byte address 0x14) reads 0, and the status register (byte address 0x20) reads 0.
- R2: Control bit 7 is the enable. Writing it as 1 starts the watchdog. No later write can clear it; only `rst_n` clears it.
- R3: Any write to the control register restarts the timeout from zero, whatever the written data (including a 0 in bit 7), so periodic writes keep `wdt_rst_req` low.
- R4: Control bits 11:8 hold the timeout T in seconds, where one second is TICK_CYCLES clock cycles. `wdt_rst_req` rises exactly T*TICK_CYCLES cycles after the clock edge that takes the last control write. A field value of 0 behaves as 1.
- R5: A new timeout written while the watchdog runs takes effect at once. The expiry is then counted from that write using the new value, whether the new value is shorter or longer.
- R6: On expiry, `wdt_rst_req` stays high for exactly RST_CYCLES consecutive cycles.
- R7: Status bit 31 is set on expiry and stays set through `rst_n`. It is cleared only by `por_n` or by a status write with bit 31 = 1. A status write with bit 31 = 0 leaves it unchanged. All other status bits read 0.
- R8: Byte address 0x1C reads FW_VERSION in bits 15:0 and zeros in bits 31:16. Unmapped addresses, and any read with `bus_rd` low, return 0.
- R9: Control bits other than 7 are stored as written and read back unchanged. The control register changes only on a control write or on `rst_n`.
- R10: While the enable bit is 0, the timer never expires and `wdt_rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset; clears the control register and the timer |
| por_n | input | 1 | Active-low power-on reset; also clears the reset-cause flag and the request pulse |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; gates `bus_rdata` |
| bus_addr | input | 8 | Byte address of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| wdt_rst_req | output | 1 | Reset request pulse raised on expiry |

## Verification
Timeouts are tried with random values from 1 to 15, plus 0 and 15 as directed cases. Each measured gap from the last write to the rising request must equal the effective timeout times the tick length. This separates a correct prescaler from an off-by-one tick, and catches a missing zero-to-one mapping. Random keep-alive writes carrying random data arrive at random spacings shorter than the timeout. Because some of them write 0 in bit 7, they show both that every write kicks the timer and that the enable cannot be cleared. Shrinking and growing the timeout mid-count shows that the new limit is counted from that write. System-reset, power-on-reset and write-one-to-clear sequences on the cause flag tell the two reset domains apart.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [7:0] CTRL_ADDR   = 8'h14;
  localparam logic [7:0] VER_ADDR    = 8'h1C;
  localparam logic [7:0] STAT_ADDR   = 8'h20;

  localparam int unsigned EN_BIT     = 7;
  localparam int unsigned TMO_LSB    = 8;
  localparam int unsigned TMO_W      = 4;
  localparam int unsigned CAUSE_BIT  = 31;

  // a programmed timeout of zero seconds behaves as one second
  function automatic logic [TMO_W-1:0] eff_limit(input logic [TMO_W-1:0] field);
    return (field == '0) ? TMO_W'(1) : field;
  endfunction

  // true when the elapsed-second count reaches the limit on this tick
  function automatic logic limit_hit(input logic [TMO_W-1:0] elapsed,
                                     input logic [TMO_W-1:0] limit);
    return ({1'b0, elapsed} + (TMO_W+1)'(1)) >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             kick,
  input  logic [TMO_W-1:0] limit,
  output logic             tick,
  output logic             expire
);

  localparam int unsigned PRESC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(TICK_CYCLES - 1);

  logic [PRESC_W-1:0] presc_q;
  logic [TMO_W-1:0]   secs_q;
  logic               restart;

  assign tick    = enable && !kick && (presc_q == PRESC_LAST);
  assign expire  = tick && limit_hit(secs_q, eff_limit(limit));
  assign restart = !enable || kick || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      secs_q  <= '0;
    end else if (restart) begin
      presc_q <= '0;
      secs_q  <= '0;
    end else if (tick) begin
      presc_q <= '0;
      secs_q  <= secs_q + TMO_W'(1);
    end else begin
      presc_q <= presc_q + PRESC_W'(1);
    end
  end

  assert_kick_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (presc_q == '0 && secs_q == '0));

  assert_idle_no_expire_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !expire);

  assert_presc_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= PRESC_LAST);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter logic [15:0] FW_VERSION = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic             expire,
  output logic [31:0]      bus_rdata,
  output logic             enable,
  output logic [TMO_W-1:0] limit,
  output logic             kick
);

  logic [31:0] ctrl_q;
  logic        cause_q;
  logic        stat_wr;
  logic        cause_clr;

  assign kick      = bus_wr && (bus_addr == CTRL_ADDR);
  assign stat_wr   = bus_wr && (bus_addr == STAT_ADDR);
  assign cause_clr = stat_wr && bus_wdata[CAUSE_BIT];
  assign enable    = ctrl_q[EN_BIT];
  assign limit     = ctrl_q[TMO_LSB +: TMO_W];

  // enable bit can only be set by software; the rest is plain storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (kick) begin
      ctrl_q <= bus_wdata | (ctrl_q & (32'd1 << EN_BIT));
    end
  end

  // reset-cause flag lives in the power-on domain
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (expire) begin
      cause_q <= 1'b1;
    end else if (cause_clr) begin
      cause_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        CTRL_ADDR: bus_rdata = ctrl_q;
        VER_ADDR:  bus_rdata = {16'h0000, FW_VERSION};
        STAT_ADDR: bus_rdata = {cause_q, 31'd0};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_enable_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> enable);

  assert_ctrl_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !kick |=> $stable(ctrl_q));

  assert_cause_set_R7: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> cause_q);

  assert_cause_holds_R7: assert property (@(posedge clk) disable iff (!por_n)
    (cause_q && !cause_clr) |=> cause_q);

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic expire,
  output logic rst_req
);

  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (expire) begin
      cnt_q <= CNT_W'(RST_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign rst_req = (cnt_q != '0);

  assert_pulse_starts_R6: assert property (@(posedge clk) disable iff (!por_n)
    expire |=> rst_req);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(expire));

endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50_000_000,
  parameter int unsigned RST_CYCLES  = 16,
  parameter logic [15:0] FW_VERSION  = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_req
);

  logic             enable;
  logic             kick;
  logic             tick;
  logic             expire;
  logic [TMO_W-1:0] limit;

  wdg_regs #(.FW_VERSION(FW_VERSION)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .expire    (expire),
    .bus_rdata (bus_rdata),
    .enable    (enable),
    .limit     (limit),
    .kick      (kick)
  );

  wdg_timebase #(.TICK_CYCLES(TICK_CYCLES)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .kick   (kick),
    .limit  (limit),
    .tick   (tick),
    .expire (expire)
  );

  wdg_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk     (clk),
    .por_n   (por_n),
    .expire  (expire),
    .rst_req (wdt_rst_req)
  );

  assert_expire_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);

endmodule

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb;

  localparam int unsigned TICK = 8;
  localparam int unsigned RSTC = 5;
  localparam logic [15:0] VER  = 16'hA5C3;

  localparam logic [7:0] A_CTRL = 8'h14;
  localparam logic [7:0] A_VER  = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  sec_watchdog #(.TICK_CYCLES(TICK), .RST_CYCLES(RSTC), .FW_VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req)
  );

  always #2.5 clk = ~clk;

  function automatic int exp_gap(input int field);
    return ((field == 0) ? 1 : field) * TICK;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired: actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // called right after wr(): counts cycles from the write edge to the request
  task automatic gap(output int k);
    k = 0;
    while (!wdt_rst_req && k < 1000) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
  endtask

  task automatic width(output int w);
    w = 0;
    while (wdt_rst_req && w < 100) begin
      w++;
      @(posedge clk); @(negedge clk);
    end
  endtask

  logic [31:0] rv;
  int k;
  int w;
  bit seen;

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    chk(wdt_rst_req == 1'b0, "R1 req", wdt_rst_req, 0);
    rd(A_CTRL, rv); chk(rv == 0, "R1 ctrl", rv, 0);
    rd(A_STAT, rv); chk(rv == 0, "R1 stat", rv, 0);

    // R8 version and unmapped
    rd(A_VER, rv); chk(rv == {16'h0, VER}, "R8 version", rv, {16'h0, VER});
    rd(8'h00, rv); chk(rv == 0, "R8 unmapped", rv, 0);
    @(negedge clk); bus_addr = A_VER; #1 chk(bus_rdata == 0, "R8 no strobe", bus_rdata, 0);

    // R9 storage with enable clear
    for (int i = 0; i < 6; i++) begin
      logic [31:0] d;
      d = $urandom() & ~32'h80;
      wr(A_CTRL, d);
      rd(A_CTRL, rv); chk(rv == d, "R9 readback", rv, d);
    end

    // R10 disabled never expires
    wr(A_CTRL, 32'h0000_0100);
    seen = 0;
    repeat (100) begin @(negedge clk); if (wdt_rst_req) seen = 1; end
    chk(!seen, "R10 no request", seen, 0);
    rd(A_STAT, rv); chk(rv == 0, "R10 no flag", rv, 0);

    // R4 directed 0 and 15, then random timeouts; R6 width; R7 flag
    for (int i = 0; i < 8; i++) begin
      int t;
      t = (i == 0) ? 0 : (i == 1) ? 15 : int'($urandom_range(15, 1));
      wr(A_CTRL, 32'h80 | (t << 8));
      gap(k);
      chk(k == exp_gap(t), "R4 expiry gap", k, exp_gap(t));
      width(w);
      chk(w == RSTC, "R6 pulse width", w, RSTC);
      rd(A_STAT, rv); chk(rv == 32'h8000_0000, "R7 flag set", rv, 32'h8000_0000);
    end

    // R2 write 0 keeps enable, and still kicks with timeout 0 -> 1 second
    wr(A_CTRL, 32'h0);
    gap(k);
    chk(k == TICK, "R2 enable kept, runs", k, TICK);
    width(w);
    rd(A_CTRL, rv); chk(rv == 32'h80, "R2 bit7 locked", rv, 32'h80);

    // R3 random keep-alive writes with random data (bit7 random)
    wr(A_CTRL, 32'h0000_0480);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      int n;
      logic [31:0] d;
      n = int'($urandom_range(4 * TICK - 3, 1));
      repeat (n) begin @(negedge clk); if (wdt_rst_req) seen = 1; end
      d = ($urandom() & ~32'h0F00) | 32'h0400;
      if ($urandom_range(1, 0) == 0) d = d & ~32'h80;
      wr(A_CTRL, d);
      if (wdt_rst_req) seen = 1;
    end
    chk(!seen, "R3 kicks prevent expiry", seen, 0);
    gap(k);
    chk(k == 4 * TICK, "R3 gap after last kick", k, 4 * TICK);
    width(w);

    // R5 shrink and grow timeout while running
    wr(A_CTRL, 32'h0A80);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h0380);
    gap(k);
    chk(k == 3 * TICK, "R5 shorter timeout", k, 3 * TICK);
    width(w);
    wr(A_CTRL, 32'h0280);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h0680);
    gap(k);
    chk(k == 6 * TICK, "R5 longer timeout", k, 6 * TICK);
    width(w);

    // R7 flag survives rst_n; write 0 keeps; write 1 clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_STAT, rv); chk(rv == 32'h8000_0000, "R7 survives rst_n", rv, 32'h8000_0000);
    rd(A_CTRL, rv); chk(rv == 0, "R2 cleared by rst_n", rv, 0);
    wr(A_STAT, 32'h7FFF_FFFF);
    rd(A_STAT, rv); chk(rv == 32'h8000_0000, "R7 write 0 keeps", rv, 32'h8000_0000);
    wr(A_STAT, 32'h8000_0000);
    rd(A_STAT, rv); chk(rv == 0, "R7 write 1 clears", rv, 0);

    // R7 por_n clears
    wr(A_CTRL, 32'h0180);
    gap(k);
    width(w);
    rd(A_STAT, rv); chk(rv == 32'h8000_0000, "R7 set again", rv, 32'h8000_0000);
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    rd(A_STAT, rv); chk(rv == 0, "R7 cleared by por_n", rv, 0);
    chk(wdt_rst_req == 1'b0, "R1 req after por", wdt_rst_req, 0);

    finish_run();
  end

endmodule